// File: doc/BRIEF.md
# Selectable Buzzer Divider Output

This block drives one output pin with a square wave of even duty, meant for a piezo buzzer. The wave comes from a free-running prescaler. Two prescaler chains exist: one advances on a fast-clock strobe and one on a slow-clock strobe. A mode input or a base-force input chooses which chain feeds the output. An 8-bit control register holds an enable bit, a 2-bit rate code and five spare bits, and is reached through a plain write strobe and a read bus.

The selected tap is registered through an output flop that changes only when the tap itself toggles. This means the pin never shows a runt pulse, either when the output starts or when it stops. While the divider path is idle, the pin carries the level of an external port latch. The rate code is locked whenever the output is enabled, so the frequency cannot change under a running tone.

Top module: `bzd_buzzer_out`

## Requirements
- R1: After reset the control register reads 0x00 and `buzz_pin` equals `port_bit`.
- R2: Control register layout: bit 7 is enable (1 = on), bits 6:5 are the rate code, bits 4:0 are spare. `rd_data` always shows the stored register.
- R3: With the fast base selected (`slow_mode` = 0 and `slow_force` = 0), rate codes 0, 1, 2 and 3 give a period of 8192, 4096, 2048 and 1024 `fc_tick` strobes.
- R4: With `slow_mode` = 1 or `slow_force` = 1, rate codes 0 to 3 give a period of 32, 16, 8 and 4 `fs_tick` strobes.
- R5: A write leaves bits 6:5 unchanged whenever enable is already 1. This includes a write that clears enable. The other bits of that write still take effect.
- R6: While running, high time and low time are each exactly half the period. The pin changes only on a toggle of the selected tap.
- R7: While the divider path is idle, `buzz_pin` follows `port_bit` in the same cycle.
- R8: Bits 4:0 are stored and read back unchanged, and they have no effect on the output wave.
- R9: Clearing enable takes effect at the next toggle of the selected tap. The half-period in progress completes at full length, after which the pin returns to `port_bit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_tick | input | 1 | Fast-base strobe; advances the fast prescaler |
| fs_tick | input | 1 | Slow-base strobe; advances the slow prescaler |
| slow_mode | input | 1 | Low-power mode active; selects the slow base |
| slow_force | input | 1 | Forces the slow base in any mode |
| port_bit | input | 1 | Port output latch level, shown while idle |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register contents |
| buzz_pin | output | 1 | Buzzer pin level |

## Verification
The bench builds the block with its default prescaler depths of 13 fast bits and 5 slow bits. It drives `fc_tick` high every cycle and `fs_tick` once every 16 cycles. With these settings the longest fast period of 8192 cycles and every slow period fit in a short run, so all eight rate and base combinations, plus the force input, are each timed over a full high and low phase. The same settings let the bench place a disable write in the middle of a measured high phase, so the length of that final phase can be counted exactly.

// File: rtl/bzd_pkg.sv
package bzd_pkg;

    localparam int CTRL_W  = 8;
    localparam int SEL_W   = 2;
    localparam int SPARE_W = CTRL_W - 1 - SEL_W;

    // Bit 7 enable, bits 6:5 rate code, bits 4:0 spare
    typedef struct packed {
        logic               en;
        logic [SEL_W-1:0]   sel;
        logic [SPARE_W-1:0] spare;
    } ctrl_t;

    typedef enum logic {
        BASE_FAST = 1'b0,
        BASE_SLOW = 1'b1
    } base_e;

    typedef struct packed {
        logic tick;   // selected tap toggles at this edge
        logic lvl;    // tap level after the toggle
    } tap_t;

    // Tap bit position for a chain of depth log2_top and a rate code
    function automatic int tap_index(input int log2_top, input logic [SEL_W-1:0] sel);
        return log2_top - 1 - int'(sel);
    endfunction

endpackage

// File: rtl/bzd_prescaler.sv
module bzd_prescaler #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (step)
            count <= count + W'(1);
    end

    a_r6_step_by_one: assert property (@(posedge clk) disable iff (rst)
        step |=> (count == $past(count) + W'(1)));

    a_r6_hold_no_step: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(count));

endmodule

// File: rtl/bzd_tap_pick.sv
module bzd_tap_pick
    import bzd_pkg::*;
#(
    parameter int FAST_W = 13,
    parameter int SLOW_W = 5
) (
    input  logic [FAST_W-1:0] fast_cnt,
    input  logic [SLOW_W-1:0] slow_cnt,
    input  logic              fc_tick,
    input  logic              fs_tick,
    input  base_e             base,
    input  logic [SEL_W-1:0]  sel,
    output tap_t              tap
);

    logic fast_ones, slow_ones, fast_lvl, slow_lvl;
    int   fidx, sidx;

    always_comb begin
        fidx      = tap_index(FAST_W, sel);
        sidx      = tap_index(SLOW_W, sel);
        fast_ones = 1'b1;
        slow_ones = 1'b1;
        fast_lvl  = 1'b0;
        slow_lvl  = 1'b0;
        for (int b = 0; b < FAST_W; b++) begin
            if (b < fidx && !fast_cnt[b]) fast_ones = 1'b0;
            if (b == fidx)                fast_lvl  = ~fast_cnt[b];
        end
        for (int b = 0; b < SLOW_W; b++) begin
            if (b < sidx && !slow_cnt[b]) slow_ones = 1'b0;
            if (b == sidx)                slow_lvl  = ~slow_cnt[b];
        end
        if (base == BASE_SLOW) begin
            tap.tick = fs_tick && slow_ones;
            tap.lvl  = slow_lvl;
        end else begin
            tap.tick = fc_tick && fast_ones;
            tap.lvl  = fast_lvl;
        end
    end

endmodule

// File: rtl/bzd_ctrl_reg.sv
module bzd_ctrl_reg
    import bzd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl
);

    ctrl_t wd;
    assign wd = ctrl_t'(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl.en    <= wd.en;
            ctrl.spare <= wd.spare;
            if (!ctrl.en)
                ctrl.sel <= wd.sel;
        end
    end

    a_r5_sel_locked: assert property (@(posedge clk) disable iff (rst)
        (wr_en && ctrl.en) |=> $stable(ctrl.sel));

    a_r8_spare_kept: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl.spare == $past(wr_data[SPARE_W-1:0])));

    a_r2_en_written: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl.en == $past(wr_data[CTRL_W-1])));

endmodule

// File: rtl/bzd_out_latch.sv
module bzd_out_latch (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic lvl,
    input  logic en,
    input  logic port_bit,
    output logic running,
    output logic pin
);

    logic wave_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            wave_q  <= 1'b0;
        end else if (tick) begin
            running <= en;
            wave_q  <= en ? lvl : 1'b0;
        end
    end

    assign pin = running ? wave_q : port_bit;

    a_r6_edge_on_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(wave_q));

    a_r9_hold_until_tick: assert property (@(posedge clk) disable iff (rst)
        (running && !tick) |=> (running && $stable(wave_q)));

    a_r9_stop_on_tick: assert property (@(posedge clk) disable iff (rst)
        (tick && !en) |=> (!running && !wave_q));

endmodule

// File: rtl/bzd_buzzer_out.sv
module bzd_buzzer_out
    import bzd_pkg::*;
#(
    parameter int FAST_LOG = 13,
    parameter int SLOW_LOG = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fc_tick,
    input  logic              fs_tick,
    input  logic              slow_mode,
    input  logic              slow_force,
    input  logic              port_bit,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              buzz_pin
);

    localparam int MIN_LOG = 1 << SEL_W;

    ctrl_t               ctrl;
    base_e               base;
    tap_t                tap;
    logic [FAST_LOG-1:0] fast_cnt;
    logic [SLOW_LOG-1:0] slow_cnt;
    logic                running;

    initial begin
        a_depth_ok: assert (FAST_LOG >= MIN_LOG && SLOW_LOG >= MIN_LOG);
    end

    assign base    = (slow_mode || slow_force) ? BASE_SLOW : BASE_FAST;
    assign rd_data = CTRL_W'(ctrl);

    bzd_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    bzd_prescaler #(.W(FAST_LOG)) u_fast_pre (
        .clk   (clk),
        .rst   (rst),
        .step  (fc_tick),
        .count (fast_cnt)
    );

    bzd_prescaler #(.W(SLOW_LOG)) u_slow_pre (
        .clk   (clk),
        .rst   (rst),
        .step  (fs_tick),
        .count (slow_cnt)
    );

    bzd_tap_pick #(.FAST_W(FAST_LOG), .SLOW_W(SLOW_LOG)) u_tap (
        .fast_cnt (fast_cnt),
        .slow_cnt (slow_cnt),
        .fc_tick  (fc_tick),
        .fs_tick  (fs_tick),
        .base     (base),
        .sel      (ctrl.sel),
        .tap      (tap)
    );

    bzd_out_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .tick     (tap.tick),
        .lvl      (tap.lvl),
        .en       (ctrl.en),
        .port_bit (port_bit),
        .running  (running),
        .pin      (buzz_pin)
    );

    a_r7_idle_follows_port: assert property (@(posedge clk) disable iff (rst)
        (!running && !tap.tick) |=> !running);

    a_r1_idle_after_reset: assert property (@(posedge clk)
        rst |=> (!running && rd_data == '0));

endmodule

// File: tb/bzd_buzzer_out_bench.sv
module bzd_buzzer_out_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FS_DIV     = 16;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic        slow;
        logic        force_slow;
        logic [1:0]  sel;
        logic [31:0] half;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 2'd0, 32'd4096},
        '{1'b0, 1'b0, 2'd1, 32'd2048},
        '{1'b0, 1'b0, 2'd2, 32'd1024},
        '{1'b0, 1'b0, 2'd3, 32'd512},
        '{1'b1, 1'b0, 2'd0, 32'd256},
        '{1'b1, 1'b0, 2'd1, 32'd128},
        '{1'b1, 1'b0, 2'd2, 32'd64},
        '{1'b1, 1'b0, 2'd3, 32'd32},
        '{1'b0, 1'b1, 2'd0, 32'd256},
        '{1'b0, 1'b1, 2'd3, 32'd32}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fc_tick = 1'b1;
    logic       fs_tick = 1'b0;
    logic       slow_mode = 1'b0;
    logic       slow_force = 1'b0;
    logic       port_bit = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       buzz_pin;

    int checks = 0;
    int fails  = 0;
    int fs_cnt = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        fs_cnt  <= (fs_cnt == FS_DIV-1) ? 0 : fs_cnt + 1;
        fs_tick <= (fs_cnt == FS_DIV-1);
    end

    bzd_buzzer_out u_bzd_buzzer_out (
        .clk        (clk),
        .rst        (rst),
        .fc_tick    (fc_tick),
        .fs_tick    (fs_tick),
        .slow_mode  (slow_mode),
        .slow_force (slow_force),
        .port_bit   (port_bit),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .buzz_pin   (buzz_pin)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_level(input logic lvl);
        int n = 0;
        while (buzz_pin !== lvl && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        wait_level(1'b0);
        wait_level(1'b1);
        hi = 0;
        while (buzz_pin === 1'b1 && hi < 20000) begin hi++; @(negedge clk); end
        lo = 0;
        while (buzz_pin === 1'b0 && lo < 20000) begin lo++; @(negedge clk); end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi, lo, tol, settle;

        // R1: reset state, port latch visible
        port_bit = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd_data == 8'h00, "R1 reset register", rd_data, 0);
        check(buzz_pin == 1'b1, "R1 pin follows port latch", buzz_pin, 1);
        port_bit = 1'b0;
        @(negedge clk);
        check(buzz_pin == 1'b0, "R7 idle pin tracks port", buzz_pin, 0);

        // R3 / R4 / R6: period table
        settle = 40;
        for (int i = 0; i < NVEC; i++) begin
            write_reg(8'h00);
            repeat (settle) @(negedge clk);
            slow_mode  = VECS[i].slow;
            slow_force = VECS[i].force_slow;
            write_reg({1'b1, VECS[i].sel, 5'b0});
            check(rd_data[6:5] == VECS[i].sel, "R2 rate code readback", rd_data[6:5], VECS[i].sel);
            measure(hi, lo);
            tol = (VECS[i].slow || VECS[i].force_slow) ? FS_DIV : 1;
            check(hi >= int'(VECS[i].half) - tol && hi <= int'(VECS[i].half) + tol,
                  (VECS[i].slow || VECS[i].force_slow) ? "R4 high time" : "R3 high time",
                  hi, VECS[i].half);
            check(hi == lo, "R6 even duty", lo, hi);
            settle = 2 * int'(VECS[i].half) + 40;
        end
        write_reg(8'h00);
        repeat (settle) @(negedge clk);
        slow_mode  = 1'b0;
        slow_force = 1'b0;

        // R5: rate code locked while enabled
        write_reg(8'hA0);
        check(rd_data == 8'hA0, "R2 enable and code 01", rd_data, 8'hA0);
        write_reg(8'hE0);
        check(rd_data == 8'hA0, "R5 code locked while enabled", rd_data, 8'hA0);
        measure(hi, lo);
        check(hi == 2048, "R5 period unchanged", hi, 2048);
        write_reg(8'h40);
        check(rd_data == 8'h20, "R5 code locked on disabling write", rd_data, 8'h20);
        repeat (4200) @(negedge clk);

        // R8: spare bits stored, no effect
        write_reg(8'h1F);
        check(rd_data == 8'h1F, "R8 spare readback", rd_data, 8'h1F);
        hi = 0;
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            if (buzz_pin !== 1'b0) hi++;
        end
        check(hi == 0, "R8 spare bits do not start output", hi, 0);
        write_reg(8'hFF);
        measure(hi, lo);
        check(hi == 512 && lo == 512, "R8 spare bits leave period", hi, 512);

        // R9: disable mid high phase, phase completes at full length
        wait_level(1'b0);
        wait_level(1'b1);
        hi = 0;
        while (buzz_pin === 1'b1 && hi < 20000) begin
            if (hi == 100) begin wr_en = 1'b1; wr_data = 8'h00; end
            if (hi == 101) wr_en = 1'b0;
            if (hi == 103) check(buzz_pin == 1'b1, "R9 no immediate clear", buzz_pin, 1);
            hi++;
            @(negedge clk);
        end
        check(hi == 512, "R9 final half full length", hi, 512);
        check(rd_data == 8'h60, "R5 code kept after clear", rd_data, 8'h60);
        lo = 0;
        for (int k = 0; k < 1200; k++) begin
            @(negedge clk);
            if (buzz_pin !== 1'b0) lo++;
        end
        check(lo == 0, "R9 pin stays at port level", lo, 0);
        port_bit = 1'b1;
        @(negedge clk);
        check(buzz_pin == 1'b1, "R7 idle pin tracks port high", buzz_pin, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule